// File: doc/BRIEF.md
# Pipelined 3x3 Matrix Multiplier

The block multiplies two square matrices of unsigned elements, R = A × B. With the default parameters it handles 3x3 matrices of 8-bit elements and gives 16-bit results. Both operand matrices sit on flat parallel input buses with no handshake of their own. The caller must hold them steady from the start pulse until done. A one-cycle start pulse, taken only while the block is idle, begins a run.

A single issue counter walks the result matrix in row-major order. In each cycle it selects one row of A and one column of B through index-driven multiplexers. A five-register pipeline then forms the dot product: issue, operand select, products, partial sum, and result write. One result element is written per clock. Each written element raises its own valid strobe for one cycle. Ready marks the cycle in which the last element is issued. Done marks the cycle after the last element lands.

Top module: `mm3_matmul`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, idle is 1, and done, ready, every strobe and every result element are 0.
- R2: Result element (i,j) equals the sum over k of a(i,k)·b(k,j). Element (r,c) of each bus sits at bits [(r·DIM+c)·width +: width]. Strobe bit i·DIM+j belongs to result (i,j).
- R3: In one run, each of the nine strobes rises exactly once. At most one strobe is high in any cycle, and the elements appear in row-major order.
- R4: The strobe for element n (n = i·DIM+j) is high in the fourth cycle plus n cycles after the clock edge that accepts start.
- R5: Ready is high for exactly one cycle per run, 8 cycles after the accepting edge, and never while idle.
- R6: Done is high for exactly one cycle, 13 cycles after the accepting edge. Idle is high in that same cycle. This latency is 9 issues plus the pipeline depth of 5 minus one.
- R7: Idle is low from the accepting edge until done. A start during a run is ignored, and no strobe is high while idle.
- R8: A result element keeps its value in every cycle in which its strobe is low, including after the operands change between runs.
- R9: A sum that overflows is truncated modulo 2^16. With every element at 255, each result is 64003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when sampled high while idle |
| a_mat | input | DIM·DIM·EW | Left operand, row-major flat bus |
| b_mat | input | DIM·DIM·EW | Right operand, row-major flat bus |
| r_mat | output | DIM·DIM·RW | Result matrix, row-major flat bus, registered |
| r_vld | output | DIM·DIM | One write strobe per result element |
| ready | output | 1 | High in the cycle the last element is issued |
| done | output | 1 | One-cycle pulse after the last result is written |
| idle | output | 1 | High when no run is active |

## Verification
The properties assume that start is the only control input. They also assume that the operand buses do not change while idle is low, since results are only compared against the values present at the start pulse. The bench changes a_mat and b_mat only while the block is idle. It raises start in a mid-run cycle, where the block ignores it, but it never touches the operands until done has been observed.

// File: rtl/mm3_pkg.sv
package mm3_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } mm3_state_e;
endpackage

// File: rtl/mm3_ctrl.sv
module mm3_ctrl
  import mm3_pkg::*;
#(
  parameter int unsigned DIM = 3,
  parameter int unsigned IW  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   last_wr,
  output logic                   iss_vld,
  output logic [$clog2(DIM)-1:0] row,
  output logic [$clog2(DIM)-1:0] col,
  output logic [IW-1:0]          lin,
  output logic                   ready,
  output logic                   done,
  output logic                   idle
);
  localparam int unsigned RIW = $clog2(DIM);
  localparam logic [RIW-1:0] COL_LAST = RIW'(DIM - 1);
  localparam logic [IW-1:0]  LIN_LAST = IW'(DIM * DIM - 1);

  mm3_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      row   <= '0;
      col   <= '0;
      lin   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_ISSUE;
          row   <= '0;
          col   <= '0;
          lin   <= '0;
        end
        ST_ISSUE: begin
          lin <= lin + 1'b1;
          if (col == COL_LAST) begin
            col <= '0;
            row <= row + 1'b1;
          end else begin
            col <= col + 1'b1;
          end
          if (lin == LIN_LAST) state <= ST_DRAIN;
        end
        ST_DRAIN: if (last_wr) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign iss_vld = (state == ST_ISSUE);
  assign ready   = (state == ST_ISSUE) && (lin == LIN_LAST);
  assign idle    = (state == ST_IDLE);
endmodule

// File: rtl/mm3_dot.sv
module mm3_dot #(
  parameter int unsigned DIM = 3,
  parameter int unsigned EW  = 8,
  parameter int unsigned RW  = 16,
  parameter int unsigned IW  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DIM*DIM*EW-1:0]  a_flat,
  input  logic [DIM*DIM*EW-1:0]  b_flat,
  input  logic                   iss_vld,
  input  logic [$clog2(DIM)-1:0] row,
  input  logic [$clog2(DIM)-1:0] col,
  input  logic [IW-1:0]          lin,
  output logic                   wr_vld,
  output logic [IW-1:0]          wr_idx,
  output logic [RW-1:0]          wr_sum
);
  localparam int unsigned PW = 2 * EW;

  logic [EW-1:0] op_a [DIM];
  logic [EW-1:0] op_b [DIM];
  logic [PW-1:0] prod [DIM];
  logic [RW-1:0] part_q, part_n, tail_q;
  logic          s1_vld, s2_vld, s3_vld;
  logic [IW-1:0] s1_idx, s2_idx, s3_idx;

  // stage 1: select row i of A and column j of B
  for (genvar k = 0; k < DIM; k++) begin : g_sel
    always_ff @(posedge clk) begin
      op_a[k] <= a_flat[(int'(row) * DIM + k) * EW +: EW];
      op_b[k] <= b_flat[(k * DIM + int'(col)) * EW +: EW];
    end
    // stage 2: one product per lane
    always_ff @(posedge clk) begin
      prod[k] <= op_a[k] * op_b[k];
    end
  end

  always_comb begin
    part_n = '0;
    for (int k = 0; k < DIM - 1; k++) part_n = part_n + RW'(prod[k]);
  end

  // stage 3: partial sum plus the last product carried alongside
  always_ff @(posedge clk) begin
    part_q <= part_n;
    tail_q <= RW'(prod[DIM-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
      s3_vld <= 1'b0;
    end else begin
      s1_vld <= iss_vld;
      s2_vld <= s1_vld;
      s3_vld <= s2_vld;
    end
  end

  always_ff @(posedge clk) begin
    s1_idx <= lin;
    s2_idx <= s1_idx;
    s3_idx <= s2_idx;
  end

  assign wr_vld = s3_vld;
  assign wr_idx = s3_idx;
  assign wr_sum = part_q + tail_q;
endmodule

// File: rtl/mm3_store.sv
module mm3_store #(
  parameter int unsigned NEL = 9,
  parameter int unsigned RW  = 16,
  parameter int unsigned IW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vld,
  input  logic [IW-1:0]     wr_idx,
  input  logic [RW-1:0]     wr_sum,
  output logic [NEL*RW-1:0] r_flat,
  output logic [NEL-1:0]    r_vld
);
  for (genvar n = 0; n < NEL; n++) begin : g_el
    logic          hit;
    logic [RW-1:0] res_q;
    assign hit = wr_vld && (wr_idx == IW'(n));
    always_ff @(posedge clk) begin
      if (rst) begin
        res_q    <= '0;
        r_vld[n] <= 1'b0;
      end else begin
        r_vld[n] <= hit;
        if (hit) res_q <= wr_sum;
      end
    end
    assign r_flat[n*RW +: RW] = res_q;
  end
endmodule

// File: rtl/mm3_matmul.sv
module mm3_matmul #(
  parameter int unsigned DIM = 3,
  parameter int unsigned EW  = 8,
  parameter int unsigned RW  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [DIM*DIM*EW-1:0] a_mat,
  input  logic [DIM*DIM*EW-1:0] b_mat,
  output logic [DIM*DIM*RW-1:0] r_mat,
  output logic [DIM*DIM-1:0]    r_vld,
  output logic                  ready,
  output logic                  done,
  output logic                  idle
);
  localparam int unsigned NEL = DIM * DIM;
  localparam int unsigned IW  = $clog2(NEL);
  localparam int unsigned RIW = $clog2(DIM);

  logic           iss_vld, wr_vld;
  logic [RIW-1:0] row, col;
  logic [IW-1:0]  lin, wr_idx;
  logic [RW-1:0]  wr_sum;

  mm3_ctrl #(.DIM(DIM), .IW(IW)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .last_wr(r_vld[NEL-1]),
    .iss_vld(iss_vld), .row(row), .col(col), .lin(lin),
    .ready(ready), .done(done), .idle(idle)
  );

  mm3_dot #(.DIM(DIM), .EW(EW), .RW(RW), .IW(IW)) dot_i (
    .clk(clk), .rst(rst), .a_flat(a_mat), .b_flat(b_mat),
    .iss_vld(iss_vld), .row(row), .col(col), .lin(lin),
    .wr_vld(wr_vld), .wr_idx(wr_idx), .wr_sum(wr_sum)
  );

  mm3_store #(.NEL(NEL), .RW(RW), .IW(IW)) store_i (
    .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_idx(wr_idx), .wr_sum(wr_sum),
    .r_flat(r_mat), .r_vld(r_vld)
  );
endmodule

// File: rtl/mm3_matmul_chk.sv
module mm3_matmul_chk #(
  parameter int unsigned NEL = 9,
  parameter int unsigned RW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [NEL*RW-1:0] r_mat,
  input logic [NEL-1:0]    r_vld,
  input logic              ready,
  input logic              done,
  input logic              idle
);
  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(r_vld)); // R3
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (rst) ready |-> !idle); // R5
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst) ready |=> !ready); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> idle); // R6
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (rst) r_vld[NEL-1] |=> done); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) idle |-> (r_vld == '0)); // R7
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst) (idle && start) |=> !idle); // R7

  for (genvar n = 0; n < NEL; n++) begin : g_hold
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
      !r_vld[n] |-> $stable(r_mat[n*RW +: RW])); // R8
  end
endmodule

bind mm3_matmul mm3_matmul_chk #(.NEL(NEL), .RW(RW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .r_mat(r_mat), .r_vld(r_vld),
  .ready(ready), .done(done), .idle(idle)
);

// File: tb/mm3_matmul_tb_top.sv
module mm3_matmul_tb_top;
  localparam int DIM = 3;
  localparam int EW  = 8;
  localparam int RW  = 16;
  localparam int NEL = DIM * DIM;

  typedef struct {
    int idx;
    int val;
    int cyc;
  } exp_t;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start = 1'b0;
  logic [NEL*EW-1:0]   a_mat = '0;
  logic [NEL*EW-1:0]   b_mat = '0;
  logic [NEL*RW-1:0]   r_mat;
  logic [NEL-1:0]      r_vld;
  logic                ready, done, idle;

  mm3_matmul #(.DIM(DIM), .EW(EW), .RW(RW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .a_mat(a_mat), .b_mat(b_mat),
    .r_mat(r_mat), .r_vld(r_vld), .ready(ready), .done(done), .idle(idle)
  );

  always #5 clk = ~clk;

  int   cyc = 0;
  int   n_chk = 0, n_err = 0;
  int   run_cyc = -1000;
  int   done_cyc = -1, done_cnt = 0, ready_cnt = 0;
  int   ma [DIM][DIM];
  int   mb [DIM][DIM];
  int   last_r [NEL];
  exp_t sb [$];
  exp_t e;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as strobes appear
  always @(negedge clk) begin
    if (!rst) begin
      if (r_vld != '0) begin
        chk($onehot(r_vld), "R3", "strobes in one cycle", $countones(r_vld), 1);
        for (int n = 0; n < NEL; n++) begin
          if (r_vld[n]) begin
            if (sb.size() == 0) begin
              chk(1'b0, "R7", "strobe with nothing pending", n, -1);
            end else begin
              e = sb.pop_front();
              chk(n == e.idx, "R3", "row-major order", n, e.idx);
              chk(int'(r_mat[n*RW +: RW]) == e.val, "R2", "result value",
                  r_mat[n*RW +: RW], e.val);
              chk(cyc == e.cyc, "R4", "strobe cycle", cyc, e.cyc);
            end
          end
        end
      end
      if (ready) begin
        ready_cnt++;
        chk(cyc == run_cyc + 8, "R5", "ready cycle", cyc, run_cyc + 8);
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
        chk(idle, "R6", "idle together with done", idle, 1);
      end
    end
  end

  task automatic pack();
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        a_mat[(i*DIM+j)*EW +: EW] = EW'(ma[i][j]);
        b_mat[(i*DIM+j)*EW +: EW] = EW'(mb[i][j]);
      end
  endtask

  // driver: pulse start, push the nine expected items, await done
  task automatic run(input bit poke_mid);
    int d0, r0, guard;
    exp_t x;
    @(negedge clk);
    pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run_cyc = cyc;
    d0 = done_cnt;
    r0 = ready_cnt;
    chk(!idle, "R7", "idle low after start", idle, 0);
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        int s = 0;
        for (int k = 0; k < DIM; k++) s += ma[i][k] * mb[k][j];
        x.idx = i * DIM + j;
        x.val = s % 65536;
        x.cyc = run_cyc + 4 + x.idx;
        last_r[x.idx] = x.val;
        sb.push_back(x);
      end
    if (poke_mid) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done_cnt == d0 && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk(done_cnt == d0 + 1, "R6", "done pulses", done_cnt - d0, 1);
    chk(done_cyc == run_cyc + 13, "R6", "done latency", done_cyc - run_cyc, 13);
    chk(ready_cnt == r0 + 1, "R5", "ready pulses", ready_cnt - r0, 1);
    chk(sb.size() == 0, "R3", "elements left unwritten", sb.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(idle, "R1", "idle after reset", idle, 1);
    chk(!done && !ready, "R1", "done/ready after reset", {done, ready}, 0);
    chk(r_vld == '0, "R1", "strobes after reset", r_vld, 0);
    chk(r_mat == '0, "R1", "results after reset", r_mat == '0, 1);

    // identity times B
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        ma[i][j] = (i == j) ? 1 : 0;
        mb[i][j] = i * DIM + j + 1;
      end
    run(1'b0);

    // structured pattern
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        ma[i][j] = i + 2 * j + 1;
        mb[i][j] = ((3 * i + j) * 7 + 3) % 256;
      end
    run(1'b0);

    // overflow wrap
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        ma[i][j] = 255;
        mb[i][j] = 255;
      end
    run(1'b0);
    chk(int'(r_mat[0 +: RW]) == 64003, "R9", "wrapped sum", r_mat[0 +: RW], 64003);

    // mixed values, start poked mid-run
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        ma[i][j] = (i * 37 + j * 91 + 5) % 256;
        mb[i][j] = (i * 113 + j * 29 + 200) % 256;
      end
    run(1'b1);
    repeat (10) @(negedge clk);
    chk(idle, "R7", "idle after ignored start", idle, 1);
    chk(sb.size() == 0, "R7", "pending items after ignored start", sb.size(), 0);

    // results hold while operands change
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        ma[i][j] = 17;
        mb[i][j] = 3;
      end
    pack();
    repeat (6) @(negedge clk);
    for (int n = 0; n < NEL; n++)
      chk(int'(r_mat[n*RW +: RW]) == last_r[n], "R8", "held result",
          r_mat[n*RW +: RW], last_r[n]);

    // back-to-back run with the new operands
    run(1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule